// File: doc/BRIEF.md
# Shiftable Comparand and Mask Register File

This block holds the data registers that sit in front of a content-addressable match array. There are three registers. The comparand holds the search word. Mask register 1 is kept as two banked copies, one for the foreground context and one for the background context. Mask register 2 is a single unbanked register. Software-side control loads these registers from a write-data bus. The comparand and mask register 2 can also be moved by one bit position per shift command.

A load can be gated by a write mask. Each destination bit whose write-mask bit is HIGH keeps its old value, and only the bits whose mask bit is LOW take the new data. The comparison mask output gives the match array the mask that is currently selected. That is the active copy of mask register 1, or mask register 2, or all zeros when masking is off. The comparand output feeds the array directly.

Top module: `cam_data_regs`

## Requirements
- R1: While reset is held, and in the first cycle after it, the comparand, both mask-1 copies and mask 2 are all zero.
- R2: With wrDest = 1 (comparand) and wrMaskSel = 0 or 3 (no write mask), the comparand equals wrData after the next rising clock edge.
- R3: With a write mask selected (wrMaskSel = 1: active mask-1 copy, wrMaskSel = 2: mask 2), each destination bit whose write-mask bit is 1 keeps its value. Each bit whose write-mask bit is 0 takes the matching wrData bit.
- R4: With shiftEn = 1 and shiftTarget = 0, the comparand shifts by one bit. It shifts toward the MSB when shiftLeft = 1 and toward the LSB otherwise. The vacated bit is filled with 0 and the bit shifted out is discarded.
- R5: With shiftEn = 1 and shiftTarget = 1, mask 2 shifts by one bit, using the same direction and fill rules as R4.
- R6: A write with wrDest = 2 updates only the mask-1 copy chosen by bgSel (0: foreground, 1: background). The other copy is unchanged.
- R7: With cmpMaskSel = 1, effMask shows the foreground mask-1 copy when bgSel = 0 and the background copy when bgSel = 1. It follows bgSel within the same cycle.
- R8: effMask equals mask 2 when cmpMaskSel = 2, and all zeros when cmpMaskSel = 0 or 3.
- R9: When a write and a shift target the same register in one cycle, only the write takes effect. A shift of the other shiftable register in that cycle still happens.
- R10: A register that is neither written nor shifted in a cycle holds its value. wrDest = 0 means no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| wrData | input | WIDTH | Write data |
| wrDest | input | 2 | Write destination: 0 none, 1 comparand, 2 mask 1 (active copy), 3 mask 2 |
| wrMaskSel | input | 2 | Write mask: 0/3 none, 1 active mask-1 copy, 2 mask 2 |
| shiftEn | input | 1 | Shift command strobe |
| shiftTarget | input | 1 | Shift target: 0 comparand, 1 mask 2 |
| shiftLeft | input | 1 | Direction: 1 toward MSB, 0 toward LSB |
| bgSel | input | 1 | Active context: 0 foreground, 1 background |
| cmpMaskSel | input | 2 | Comparison mask: 0/3 off, 1 active mask-1 copy, 2 mask 2 |
| comparand | output | WIDTH | Current comparand |
| effMask | output | WIDTH | Effective comparison mask |

## Verification
The assertions check several properties on every cycle. They check the shift results of both shiftable registers, including zero fill. They check that protected bits are preserved on every comparand load and that the idle mask-1 copy is untouched by foreground writes. They also check that a disabled comparison mask reads as zeros. Other behaviour shows up only in the bench's swept scenarios: which copy a context switch exposes, write-over-shift priority, and that unrelated registers hold. In those sweeps, every combination of destination, write mask, shift command and context is run against data patterns and compared with an arithmetic model.

// File: rtl/cam_data_regs_pkg.sv
package cam_data_regs_pkg;

  typedef enum logic [1:0] {
    DEST_NONE = 2'd0,
    DEST_CMP  = 2'd1,
    DEST_MR1  = 2'd2,
    DEST_MR2  = 2'd3
  } dest_e;

  typedef enum logic [1:0] {
    MSEL_OFF  = 2'd0,
    MSEL_MR1  = 2'd1,
    MSEL_MR2  = 2'd2,
    MSEL_OFF2 = 2'd3
  } msel_e;

  typedef struct packed {
    logic  wrCmp;
    logic  wrMr1Fg;
    logic  wrMr1Bg;
    logic  wrMr2;
    logic  shCmp;
    logic  shMr2;
    logic  shLeft;
    logic  useBg;
    msel_e wrMaskSel;
    msel_e cmpMaskSel;
  } strobe_t;

endpackage

// File: rtl/cam_data_regs_ctrl.sv
module cam_data_regs_ctrl
  import cam_data_regs_pkg::*;
(
  input  logic [1:0] wrDest,
  input  logic [1:0] wrMaskSel,
  input  logic       shiftEn,
  input  logic       shiftTarget,
  input  logic       shiftLeft,
  input  logic       bgSel,
  input  logic [1:0] cmpMaskSel,
  output strobe_t    strb
);

  dest_e dest;
  assign dest = dest_e'(wrDest);

  always_comb begin
    strb            = '0;
    strb.wrCmp      = (dest == DEST_CMP);
    strb.wrMr1Fg    = (dest == DEST_MR1) && !bgSel;
    strb.wrMr1Bg    = (dest == DEST_MR1) && bgSel;
    strb.wrMr2      = (dest == DEST_MR2);
    // a write to the same register wins over a shift
    strb.shCmp      = shiftEn && !shiftTarget && !strb.wrCmp;
    strb.shMr2      = shiftEn && shiftTarget && !strb.wrMr2;
    strb.shLeft     = shiftLeft;
    strb.useBg      = bgSel;
    strb.wrMaskSel  = msel_e'(wrMaskSel);
    strb.cmpMaskSel = msel_e'(cmpMaskSel);
  end

endmodule

// File: rtl/cam_data_regs_dp.sv
module cam_data_regs_dp
  import cam_data_regs_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] wrData,
  input  strobe_t          strb,
  output logic [WIDTH-1:0] comparand,
  output logic [WIDTH-1:0] effMask
);

  localparam logic [WIDTH-1:0] ZERO = '0;

  logic [WIDTH-1:0] cmpQ, mr1FgQ, mr1BgQ, mr2Q;
  logic [WIDTH-1:0] mr1Active, wrMask;
  logic [WIDTH-1:0] cmpShifted, mr2Shifted;

  assign mr1Active = strb.useBg ? mr1BgQ : mr1FgQ;

  function automatic logic [WIDTH-1:0] pickMask(msel_e sel, logic [WIDTH-1:0] m1,
                                                logic [WIDTH-1:0] m2);
    case (sel)
      MSEL_MR1: pickMask = m1;
      MSEL_MR2: pickMask = m2;
      default:  pickMask = ZERO;
    endcase
  endfunction

  function automatic logic [WIDTH-1:0] merge(logic [WIDTH-1:0] oldV, logic [WIDTH-1:0] newV,
                                             logic [WIDTH-1:0] keep);
    merge = (oldV & keep) | (newV & ~keep);
  endfunction

  assign wrMask  = pickMask(strb.wrMaskSel, mr1Active, mr2Q);
  assign effMask = pickMask(strb.cmpMaskSel, mr1Active, mr2Q);

  // one-bit shifters, zero fill, for each shiftable register
  for (genvar g = 0; g < 2; g++) begin : g_shift
    logic [WIDTH-1:0] src, res;
    assign src = (g == 0) ? cmpQ : mr2Q;
    assign res = strb.shLeft ? {src[WIDTH-2:0], 1'b0} : {1'b0, src[WIDTH-1:1]};
  end
  assign cmpShifted = g_shift[0].res;
  assign mr2Shifted = g_shift[1].res;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpQ   <= '0;
      mr1FgQ <= '0;
      mr1BgQ <= '0;
      mr2Q   <= '0;
    end else begin
      if (strb.wrCmp)      cmpQ <= merge(cmpQ, wrData, wrMask);
      else if (strb.shCmp) cmpQ <= cmpShifted;
      if (strb.wrMr1Fg)    mr1FgQ <= merge(mr1FgQ, wrData, wrMask);
      if (strb.wrMr1Bg)    mr1BgQ <= merge(mr1BgQ, wrData, wrMask);
      if (strb.wrMr2)      mr2Q <= merge(mr2Q, wrData, wrMask);
      else if (strb.shMr2) mr2Q <= mr2Shifted;
    end
  end

  assign comparand = cmpQ;

  a_r4_cmp_left: assert property (@(posedge clk) disable iff (!rstN)
    strb.shCmp && strb.shLeft |=> comparand == ($past(comparand) << 1));
  a_r4_cmp_right: assert property (@(posedge clk) disable iff (!rstN)
    strb.shCmp && !strb.shLeft |=> comparand == ($past(comparand) >> 1));
  a_r5_mr2_left: assert property (@(posedge clk) disable iff (!rstN)
    strb.shMr2 && strb.shLeft |=> mr2Q == ($past(mr2Q) << 1));
  a_r5_mr2_right: assert property (@(posedge clk) disable iff (!rstN)
    strb.shMr2 && !strb.shLeft |=> mr2Q == ($past(mr2Q) >> 1));
  a_r3_keep_protected: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCmp |=> ((comparand ^ $past(comparand)) & $past(wrMask)) == ZERO);
  a_r6_bg_untouched: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrMr1Fg |=> $stable(mr1BgQ));

endmodule

// File: rtl/cam_data_regs.sv
module cam_data_regs
  import cam_data_regs_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] wrData,
  input  logic [1:0]       wrDest,
  input  logic [1:0]       wrMaskSel,
  input  logic             shiftEn,
  input  logic             shiftTarget,
  input  logic             shiftLeft,
  input  logic             bgSel,
  input  logic [1:0]       cmpMaskSel,
  output logic [WIDTH-1:0] comparand,
  output logic [WIDTH-1:0] effMask
);

  strobe_t strb;

  cam_data_regs_ctrl u_ctrl (
    .wrDest      (wrDest),
    .wrMaskSel   (wrMaskSel),
    .shiftEn     (shiftEn),
    .shiftTarget (shiftTarget),
    .shiftLeft   (shiftLeft),
    .bgSel       (bgSel),
    .cmpMaskSel  (cmpMaskSel),
    .strb        (strb)
  );

  cam_data_regs_dp #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrData    (wrData),
    .strb      (strb),
    .comparand (comparand),
    .effMask   (effMask)
  );

  a_r8_mask_off: assert property (@(posedge clk) disable iff (!rstN)
    (cmpMaskSel == 2'd0 || cmpMaskSel == 2'd3) |-> effMask == '0);

endmodule

// File: tb/cam_data_regs_tb.sv
`timescale 1ns/100ps
module cam_data_regs_tb;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [W-1:0] wrData = '0;
  logic [1:0]   wrDest = 2'd0;
  logic [1:0]   wrMaskSel = 2'd0;
  logic         shiftEn = 1'b0;
  logic         shiftTarget = 1'b0;
  logic         shiftLeft = 1'b0;
  logic         bgSel = 1'b0;
  logic [1:0]   cmpMaskSel = 2'd0;
  logic [W-1:0] comparand, effMask;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [W-1:0] mCmp = '0, mFg = '0, mBg = '0, mM2 = '0;

  always #2 clk = ~clk;

  cam_data_regs #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrDest(wrDest), .wrMaskSel(wrMaskSel),
    .shiftEn(shiftEn), .shiftTarget(shiftTarget), .shiftLeft(shiftLeft), .bgSel(bgSel),
    .cmpMaskSel(cmpMaskSel), .comparand(comparand), .effMask(effMask)
  );

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] sh(logic [W-1:0] v, logic left);
    return left ? (v << 1) : (v >> 1);
  endfunction

  // Check every observable register through the ports; inputs are idle here.
  task automatic checkAll(string cTag, string m1Tag, string m2Tag);
    logic keepBg;
    keepBg = bgSel;
    #0.1 check(cTag, "comparand", comparand, mCmp);
    cmpMaskSel = 2'd0; #0.1 check("R8", "mask off 0", effMask, '0);
    cmpMaskSel = 2'd3; #0.1 check("R8", "mask off 3", effMask, '0);
    cmpMaskSel = 2'd2; #0.1 check(m2Tag, "mask2", effMask, mM2);
    cmpMaskSel = 2'd1;
    bgSel = 1'b0;      #0.1 check(m1Tag, "mask1 fg", effMask, mFg);
    bgSel = 1'b1;      #0.1 check(m1Tag, "mask1 bg", effMask, mBg);
    bgSel = keepBg;    #0.1;
  endtask

  task automatic step(logic [W-1:0] d, logic [1:0] dest, logic [1:0] wms, logic sEn,
                      logic sTgt, logic sLeft, logic bg);
    logic [W-1:0] m1, wm, nCmp, nFg, nBg, nM2;
    string cTag, m1Tag, m2Tag;
    wrData = d; wrDest = dest; wrMaskSel = wms; shiftEn = sEn;
    shiftTarget = sTgt; shiftLeft = sLeft; bgSel = bg;
    m1 = bg ? mBg : mFg;
    wm = (wms == 2'd1) ? m1 : (wms == 2'd2) ? mM2 : '0;
    nCmp = mCmp; nFg = mFg; nBg = mBg; nM2 = mM2;
    cTag = "R10"; m1Tag = "R10"; m2Tag = "R10";
    if (dest == 2'd1) begin
      nCmp = (mCmp & wm) | (d & ~wm);
      cTag = (wm == '0) ? "R2" : "R3";
      if (sEn && !sTgt) cTag = "R9";
    end else if (sEn && !sTgt) begin
      nCmp = sh(mCmp, sLeft); cTag = "R4";
    end
    if (dest == 2'd2) begin
      if (bg) nBg = (mBg & wm) | (d & ~wm);
      else    nFg = (mFg & wm) | (d & ~wm);
      m1Tag = "R6";
    end else m1Tag = "R7";
    if (dest == 2'd3) begin
      nM2 = (mM2 & wm) | (d & ~wm);
      m2Tag = (sEn && sTgt) ? "R9" : "R3";
    end else if (sEn && sTgt) begin
      nM2 = sh(mM2, sLeft); m2Tag = "R5";
    end else m2Tag = "R8";
    @(posedge clk);
    #1;
    wrDest = 2'd0; shiftEn = 1'b0;
    mCmp = nCmp; mFg = nFg; mBg = nBg; mM2 = nM2;
    checkAll(cTag, m1Tag, m2Tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 checkAll("R1", "R1", "R1");
    rstN = 1'b1;
    @(posedge clk); #1 checkAll("R1", "R1", "R1");

    // directed: seed registers
    step(16'hA5C3, 2'd1, 2'd0, 0, 0, 0, 0);            // R2
    step(16'h00FF, 2'd2, 2'd0, 0, 0, 0, 0);            // R6 fg
    step(16'hF0F0, 2'd2, 2'd0, 0, 0, 0, 1);            // R6 bg
    step(16'h3C3C, 2'd3, 2'd0, 0, 0, 0, 0);
    step(16'h1234, 2'd1, 2'd1, 0, 0, 0, 1);            // R3 via bg mask
    step(16'hFFFF, 2'd1, 2'd0, 1, 0, 1, 0);            // R9 write wins
    step(16'h0000, 2'd0, 2'd0, 1, 0, 1, 0);            // R4 left, MSB dropped
    step(16'h0000, 2'd0, 2'd0, 1, 1, 0, 0);            // R5 right
    step(16'h5555, 2'd1, 2'd0, 1, 1, 1, 0);            // R9 other reg still shifts

    // near-exhaustive sweep over every control combination and data patterns
    for (int p = 0; p < 4; p++) begin
      for (int c = 0; c < 128; c++) begin
        logic [W-1:0] d;
        d = W'((p * 16'h9E37 + c * 16'h3B5D) ^ (c << (p + 3)));
        step(d, c[1:0], c[3:2], c[4], c[5], c[6], p[0] ^ c[2]);
      end
    end

    // long shift run: all bits fall out with zero fill
    step(16'h8001, 2'd1, 2'd0, 0, 0, 0, 0);
    for (int k = 0; k < W + 1; k++) step('0, 2'd0, 2'd0, 1, 0, 0, 0);
    step(16'h8001, 2'd3, 2'd0, 0, 0, 0, 0);
    for (int k = 0; k < W + 1; k++) step('0, 2'd0, 2'd0, 1, 1, 1, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule